// File: doc/BRIEF.md
# Endian-Selectable Byte Lane Memory Adapter

This block sits between the load/store stage of a processor and a data memory organised as 32-bit words. For every request it turns a byte address into a word address. For stores it also produces a four-bit byte write-enable mask and write data placed on the correct lanes. For loads it takes the word the memory returns and extracts the byte that was addressed, sign-extended to 32 bits, or it passes the whole word through.

A runtime select chooses how byte numbers map onto lanes. In big-endian numbering, byte offset 0 of a word is the most significant byte. In little-endian numbering, byte offset 0 is the least significant byte. A word request whose address is not a multiple of four raises a misalignment flag, and no write happens for it.

The memory-side outputs are registered and appear one cycle after the request. The memory must return read data in the same cycle it sees the address. The load result is registered one cycle after that.

Top module: `bytelane_mem_if`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `mem_valid`, `mem_we`, `mem_misalign` and `ld_valid` are all 0.
- R2: One cycle after a request is accepted (`req_valid`=1), `mem_valid` is 1 and `mem_addr` equals `req_addr[ADDR_W-1:2]`.
- R3: An aligned word store (`req_is_byte`=0, `req_addr[1:0]`=0) drives `mem_we`=4'b1111 and `mem_wdata`=`req_wdata`.
- R4: A byte store with `big_endian`=1 enables only lane 3-`req_addr[1:0]`. Bit k of `mem_we` covers `mem_wdata[8k+7:8k]`, and all four lanes carry `req_wdata[7:0]`. For example, storing 0x90 at byte address 6 into the word FFFFFFFF at word address 1 gives FFFF90FF.
- R5: A byte store with `big_endian`=0 enables only lane `req_addr[1:0]`, with the same data replication. The same example gives FF90FFFF.
- R6: A byte load returns, one cycle after `mem_valid`, `ld_valid`=1 and `ld_data` equal to the selected lane of `mem_rdata`. The lane follows the same rule as R4 and R5, and bit 7 of that byte is copied into `ld_data[31:8]`.
- R7: A word load returns `ld_data`=`mem_rdata` unchanged, one cycle after `mem_valid`.
- R8: A word request with `req_addr[1:0]`≠0 raises `mem_misalign` alongside `mem_valid` and drives `mem_we`=0, so memory is left unchanged. A byte request never raises `mem_misalign`.
- R9: A load never asserts any bit of `mem_we`, and `mem_we` is 0 whenever `mem_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| big_endian | input | 1 | 1 selects big-endian byte numbering, 0 little-endian |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 store, 0 load |
| req_is_byte | input | 1 | 1 byte access, 0 word access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store source value |
| mem_rdata | input | 32 | Word returned by memory for `mem_addr` |
| mem_valid | output | 1 | Memory access presented |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_we | output | 4 | Per-lane write enable |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_misalign | output | 1 | Misaligned word access flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result |

## Verification
The hardest case to reach from the ports is a store followed directly by a load of the same word. The load then reads memory in the very cycle after the partial write has landed, so a lane error only shows up if the readback carries the neighbouring bytes intact. The stimulus fills a word with all ones and writes single bytes into it in both endian modes. Back-to-back loads then read it with sign extension visible in every lane. Misaligned word stores go to a word that was filled first, and a following load proves that the word is unchanged.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;

    localparam int BYTE_W     = 8;
    localparam int LANES      = 4;
    localparam int WORD_W     = BYTE_W * LANES;
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } order_e;

    typedef struct packed {
        logic [LANE_IDX_W-1:0] lane;
        logic [LANES-1:0]      mask;
        logic                  misaligned;
    } lane_sel_t;

    typedef struct packed {
        logic                  is_byte;
        logic [LANE_IDX_W-1:0] lane;
    } load_ctx_t;

    // Byte offset within the word -> physical lane index.
    function automatic logic [LANE_IDX_W-1:0] pick_lane(
        input logic [LANE_IDX_W-1:0] off,
        input order_e                ord
    );
        logic [LANE_IDX_W-1:0] top;
        top = LANE_IDX_W'(LANES - 1);
        return (ord == ORDER_BIG) ? (top - off) : off;
    endfunction

    function automatic logic [WORD_W-1:0] sext_byte(input logic [BYTE_W-1:0] b);
        return {{(WORD_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

endpackage

// File: rtl/bytelane_decode.sv
module bytelane_decode
    import bytelane_pkg::*;
(
    input  logic [LANE_IDX_W-1:0] offset,
    input  logic                  is_byte,
    input  order_e                order,
    output lane_sel_t             sel
);
    logic [LANE_IDX_W-1:0] lane;
    logic                  bad_align;

    always_comb begin
        lane      = pick_lane(offset, order);
        bad_align = !is_byte && (offset != '0);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_mask
        assign sel.mask[k] = is_byte ? (lane == LANE_IDX_W'(k)) : !bad_align;
    end

    assign sel.lane       = lane;
    assign sel.misaligned = bad_align;

endmodule

// File: rtl/bytelane_store_pack.sv
module bytelane_store_pack
    import bytelane_pkg::*;
(
    input  logic [WORD_W-1:0] src,
    input  logic              is_byte,
    output logic [WORD_W-1:0] packed_data
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign packed_data[k*BYTE_W +: BYTE_W] =
            is_byte ? src[BYTE_W-1:0] : src[k*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/bytelane_load_extract.sv
module bytelane_load_extract
    import bytelane_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  load_ctx_t         ctx,
    output logic [WORD_W-1:0] result
);
    logic [BYTE_W-1:0] lanes [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_split
        assign lanes[k] = word_in[k*BYTE_W +: BYTE_W];
    end

    always_comb begin
        if (ctx.is_byte) result = sext_byte(lanes[ctx.lane]);
        else             result = word_in;
    end
endmodule

// File: rtl/bytelane_mem_if.sv
module bytelane_mem_if
    import bytelane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                big_endian,
    input  logic                req_valid,
    input  logic                req_is_store,
    input  logic                req_is_byte,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WORD_W-1:0]   req_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                mem_valid,
    output logic [ADDR_W-3:0]   mem_addr,
    output logic [LANES-1:0]    mem_we,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic                mem_misalign,
    output logic                ld_valid,
    output logic [WORD_W-1:0]   ld_data
);
    localparam int WADDR_W = ADDR_W - LANE_IDX_W;

    order_e            order;
    lane_sel_t         sel;
    logic [WORD_W-1:0] packed_w;
    load_ctx_t         ctx_q;
    logic              pend_load_q;
    logic [WORD_W-1:0] extracted;

    assign order = big_endian ? ORDER_BIG : ORDER_LITTLE;

    bytelane_decode u_decode (
        .offset  (req_addr[LANE_IDX_W-1:0]),
        .is_byte (req_is_byte),
        .order   (order),
        .sel     (sel)
    );

    bytelane_store_pack u_pack (
        .src         (req_wdata),
        .is_byte     (req_is_byte),
        .packed_data (packed_w)
    );

    bytelane_load_extract u_extract (
        .word_in (mem_rdata),
        .ctx     (ctx_q),
        .result  (extracted)
    );

    // Request stage: drive memory one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid    <= 1'b0;
            mem_addr     <= '0;
            mem_we       <= '0;
            mem_wdata    <= '0;
            mem_misalign <= 1'b0;
            pend_load_q  <= 1'b0;
            ctx_q        <= '0;
        end else begin
            mem_valid    <= req_valid;
            mem_misalign <= req_valid && sel.misaligned;
            pend_load_q  <= req_valid && !req_is_store;
            if (req_valid) begin
                mem_addr  <= req_addr[ADDR_W-1:LANE_IDX_W];
                mem_wdata <= packed_w;
                mem_we    <= req_is_store ? sel.mask : '0;
                ctx_q     <= '{is_byte: req_is_byte, lane: sel.lane};
            end else begin
                mem_we    <= '0;
            end
        end
    end

    // Response stage: capture extracted load data.
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= pend_load_q;
            if (pend_load_q) ld_data <= extracted;
        end
    end

    logic unused_waddr;
    assign unused_waddr = (WADDR_W == 0);

endmodule

// File: rtl/bytelane_mem_if_chk.sv
module bytelane_mem_if_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_is_store,
    input logic              req_is_byte,
    input logic [ADDR_W-1:0] req_addr,
    input logic              mem_valid,
    input logic [ADDR_W-3:0] mem_addr,
    input logic [3:0]        mem_we,
    input logic              mem_misalign,
    input logic              ld_valid
);
    assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_valid |-> (mem_we == 4'b0000));

    assert_load_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_store) |=> (mem_we == 4'b0000));

    assert_misalign_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        mem_misalign |-> (mem_valid && mem_we == 4'b0000));

    assert_byte_never_misaligned_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_byte) |=> !mem_misalign);

    assert_byte_single_lane_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_store && req_is_byte) |=> ($countones(mem_we) == 1));

    assert_word_addr_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (mem_valid && mem_addr == $past(req_addr[ADDR_W-1:2])));

    assert_load_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !$past(req_is_store)) |=> ld_valid);
endmodule

bind bytelane_mem_if bytelane_mem_if_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_is_store (req_is_store),
    .req_is_byte  (req_is_byte),
    .req_addr     (req_addr),
    .mem_valid    (mem_valid),
    .mem_addr     (mem_addr),
    .mem_we       (mem_we),
    .mem_misalign (mem_misalign),
    .ld_valid     (ld_valid)
);

// File: tb/bytelane_mem_if_tb.sv
module bytelane_mem_if_tb_top;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              big_endian = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_is_store = 1'b0;
    logic              req_is_byte = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       mem_rdata;
    logic              mem_valid;
    logic [ADDR_W-3:0] mem_addr;
    logic [3:0]        mem_we;
    logic [31:0]       mem_wdata;
    logic              mem_misalign;
    logic              ld_valid;
    logic [31:0]       ld_data;

    always #2 clk = ~clk;

    bytelane_mem_if #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .big_endian(big_endian),
        .req_valid(req_valid), .req_is_store(req_is_store),
        .req_is_byte(req_is_byte), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_rdata(mem_rdata), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_misalign(mem_misalign),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // Memory model: combinational read, per-lane write at the edge.
    logic [31:0] ram [16];
    assign mem_rdata = ram[mem_addr[3:0]];
    always @(posedge clk) begin
        for (int k = 0; k < 4; k++)
            if (mem_valid && mem_we[k]) ram[mem_addr[3:0]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
    end

    typedef struct {
        logic [29:0] addr;
        logic [3:0]  we;
        logic [31:0] wdata;
        bit          cmp_wdata;
        logic        mis;
        string       tag;
    } mem_exp_t;

    typedef struct {
        logic [31:0] data;
        string       tag;
    } ld_exp_t;

    mem_exp_t    mem_q[$];
    ld_exp_t     ld_q[$];
    logic [31:0] shadow [16];
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    function automatic int lane_of(input logic [1:0] off, input bit be);
        return be ? 3 - int'(off) : int'(off);
    endfunction

    task automatic fail(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    // Driver: present one request and queue what it must produce.
    task automatic issue(input bit st, input bit by, input bit be,
                         input logic [31:0] a, input logic [31:0] d, input string tag);
        mem_exp_t me;
        ld_exp_t  le;
        int       ln;
        bit       mis;
        logic [31:0] w;
        @(negedge clk);
        req_valid = 1'b1; req_is_store = st; req_is_byte = by;
        big_endian = be; req_addr = a; req_wdata = d;
        ln  = lane_of(a[1:0], be);
        mis = !by && (a[1:0] != 2'b00);
        me.addr = a[31:2]; me.mis = mis; me.tag = tag; me.cmp_wdata = st;
        if (!st)      me.we = 4'b0000;
        else if (by)  me.we = 4'b0001 << ln;
        else          me.we = mis ? 4'b0000 : 4'b1111;
        me.wdata = by ? {4{d[7:0]}} : d;
        mem_q.push_back(me);
        w = shadow[a[5:2]];
        if (st) begin
            for (int k = 0; k < 4; k++)
                if (me.we[k]) w[k*8 +: 8] = me.wdata[k*8 +: 8];
            shadow[a[5:2]] = w;
        end else begin
            le.tag  = tag;
            le.data = by ? {{24{w[ln*8+7]}}, w[ln*8 +: 8]} : w;
            ld_q.push_back(le);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compare outputs against queued expectations.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (mem_valid) begin
                if (mem_q.size() == 0) begin
                    checks++; fail("R2", "unexpected mem_valid", 32'(mem_valid), 32'h0);
                end else begin
                    mem_exp_t e;
                    e = mem_q.pop_front();
                    checks++;
                    if (mem_addr != e.addr) fail(e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
                    checks++;
                    if (mem_we != e.we) fail(e.tag, "mem_we", 32'(mem_we), 32'(e.we));
                    checks++;
                    if (mem_misalign != e.mis) fail(e.tag, "mem_misalign", 32'(mem_misalign), 32'(e.mis));
                    if (e.cmp_wdata) begin
                        checks++;
                        if (mem_wdata != e.wdata) fail(e.tag, "mem_wdata", mem_wdata, e.wdata);
                    end
                end
            end else begin
                checks++;
                if (mem_we != 4'b0000) fail("R9", "mem_we while idle", 32'(mem_we), 32'h0);
            end
            if (ld_valid) begin
                if (ld_q.size() == 0) begin
                    checks++; fail("R6", "unexpected ld_valid", 32'(ld_valid), 32'h0);
                end else begin
                    ld_exp_t l;
                    l = ld_q.pop_front();
                    checks++;
                    if (ld_data != l.data) fail(l.tag, "ld_data", ld_data, l.data);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            ram[i] = 32'h0; shadow[i] = 32'h0;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (mem_valid || mem_we != 0 || mem_misalign || ld_valid)
            fail("R1", "outputs in reset", {mem_valid, mem_we, mem_misalign, ld_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (mem_valid || mem_we != 0 || mem_misalign || ld_valid)
            fail("R1", "outputs after reset", {mem_valid, mem_we, mem_misalign, ld_valid}, 32'h0);

        // R3: aligned word stores in both orders, R7 word loads back
        issue(1, 0, 1, 32'h0000_0004, 32'hFFFF_FFFF, "R3");
        issue(1, 0, 0, 32'h0000_0008, 32'hFFFF_FFFF, "R3");
        issue(1, 0, 1, 32'h0000_000C, 32'h1234_5678, "R3");
        issue(0, 0, 1, 32'h0000_000C, 32'h0, "R7");
        // R4: big-endian byte 0x90 at address 6 into FFFFFFFF -> FFFF90FF
        issue(1, 1, 1, 32'h0000_0006, 32'hAAAA_AA90, "R4");
        issue(0, 0, 1, 32'h0000_0004, 32'h0, "R4");
        // R5: little-endian same store on word 2 (address 10) -> FF90FFFF
        issue(1, 1, 0, 32'h0000_000A, 32'h0000_0090, "R5");
        issue(0, 0, 0, 32'h0000_0008, 32'h0, "R5");
        // R6: byte loads every offset, both orders, back to back
        for (int o = 0; o < 4; o++) begin
            issue(0, 1, 1, 32'h0000_000C + o, 32'h0, "R6");
            issue(0, 1, 0, 32'h0000_000C + o, 32'h0, "R6");
        end
        issue(0, 1, 1, 32'h0000_0006, 32'h0, "R6");
        issue(0, 1, 0, 32'h0000_000A, 32'h0, "R6");
        // R4/R5 every offset into a zeroed word, then readback
        for (int o = 0; o < 4; o++) begin
            issue(1, 1, 1, 32'h0000_0010 + o, 32'(8'h81 + o), "R4");
            issue(1, 1, 0, 32'h0000_0014 + o, 32'(8'h41 + o), "R5");
        end
        issue(0, 0, 1, 32'h0000_0010, 32'h0, "R4");
        issue(0, 0, 0, 32'h0000_0014, 32'h0, "R5");
        // R8: misaligned word stores do not write, byte never flags
        for (int o = 1; o < 4; o++)
            issue(1, 0, o[0], 32'h0000_000C + o, 32'hDEAD_BEEF, "R8");
        issue(0, 0, 1, 32'h0000_000C, 32'h0, "R8");
        issue(0, 0, 0, 32'h0000_0005, 32'h0, "R8");
        issue(1, 1, 0, 32'h0000_0003, 32'h0000_007F, "R8");
        // R9: a load with store-like data writes nothing
        issue(0, 1, 1, 32'h0000_0004, 32'hFFFF_FFFF, "R9");
        issue(0, 0, 1, 32'h0000_0004, 32'h0, "R9");
        idle(4);
        done = 1'b1;
        checks++;
        if (mem_q.size() != 0 || ld_q.size() != 0)
            fail("R2", "outstanding expectations", 32'(mem_q.size() + ld_q.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule